// File: doc/BRIEF.md
# Four-Level Interrupt Priority Resolver

This block takes up to ten pending interrupt request flags and picks the one to be serviced next. It can also report that no request qualifies. The seven interrupt groups each have one bit in a low priority register and one bit in a high priority register. Together the two bits give the group a level from 0 to 3. Several request flags share one group, and so share its level and its enable bit.

A request takes part only when the global enable and its group enable are both set. The winner is the eligible request with the highest level. Among requests of the same level, the lowest source index wins.

The result is registered and is meant to feed the vector and sequencing logic of a CPU core. The parameter `HAS_HI` removes the high priority register: its input is then ignored and only levels 0 and 1 can occur.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `grant_valid_o` is 0, `grant_idx_o` is 0 and `grant_lvl_o` is 0.
- R2: The source-to-group map is: sources 0,1,2,3 go to groups 0,1,2,3; sources 4,5,6 go to group 4; sources 7,8 go to group 5; source 9 goes to group 6. A granted source's level equals `prio_lo_i[g] + 2*prio_hi_i[g]` for its group g.
- R3: No eligible request has a level above the level that is granted.
- R4: Among eligible requests of the granted level, the one with the lowest source index is granted.
- R5: Requests that share a group (4/5/6 and 7/8) always have equal levels and are ordered by index.
- R6: Source i is eligible only if `req_i[i]`, `en_i[7]` and `en_i[g]` are all 1, where g is the group of source i. With `en_i[7]` at 0 nothing is granted.
- R7: When no source is eligible, the outputs are valid 0, index 0 and level 0.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A change of any input first shows after the next rising edge.
- R9: With `HAS_HI` = 0, `prio_hi_i` has no effect and every level is `prio_lo_i[g]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 10 | Pending request flags, one per source |
| en_i | input | 8 | Group enables in bits 6..0, global enable in bit 7 |
| prio_lo_i | input | 7 | Low priority bit of each group |
| prio_hi_i | input | 7 | High priority bit of each group |
| grant_valid_o | output | 1 | An eligible request was found |
| grant_idx_o | output | 4 | Index of the granted source |
| grant_lvl_o | output | 2 | Level of the granted source |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench drives inputs 1 time unit after a rising edge and compares all three outputs 1 time unit after the next rising edge. Before that edge, the bench also checks that the outputs still show the previous result, which tests the single-register latency. A reference computed in the bench applies the group map, the level arithmetic and the ordering rule to sweeps of request, enable and priority patterns. The same reference also covers a second instance built without the high register.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter bit HAS_HI = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [9:0] req_i,
  input  logic [7:0] en_i,
  input  logic [6:0] prio_lo_i,
  input  logic [6:0] prio_hi_i,
  output logic       grant_valid_o,
  output logic [3:0] grant_idx_o,
  output logic [1:0] grant_lvl_o
);
  localparam int NSRC = 10;
  localparam int NGRP = 7;
  localparam int IW   = $clog2(NSRC);

  function automatic int grp_of(input int s);
    if (s < 4)      return s;
    else if (s < 7) return 4;
    else if (s < 9) return 5;
    else            return 6;
  endfunction

  logic [NGRP-1:0] hi_eff;
  assign hi_eff = HAS_HI ? prio_hi_i : '0;

  logic          nx_valid;
  logic [IW-1:0] nx_idx;
  logic [1:0]    nx_lvl;

  always_comb begin
    nx_valid = 1'b0;
    nx_idx   = '0;
    nx_lvl   = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      logic [1:0] l;
      l = {hi_eff[grp_of(s)], prio_lo_i[grp_of(s)]};
      if (req_i[s] && en_i[7] && en_i[grp_of(s)] && (!nx_valid || l >= nx_lvl)) begin
        nx_valid = 1'b1;
        nx_idx   = IW'(s);
        nx_lvl   = l;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid_o <= 1'b0;
      grant_idx_o   <= '0;
      grant_lvl_o   <= '0;
    end else begin
      grant_valid_o <= nx_valid;
      grant_idx_o   <= nx_idx;
      grant_lvl_o   <= nx_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter bit HAS_HI = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [9:0] req_i,
  input logic [7:0] en_i,
  input logic [6:0] prio_lo_i,
  input logic [6:0] prio_hi_i,
  input logic       grant_valid_o,
  input logic [3:0] grant_idx_o,
  input logic [1:0] grant_lvl_o
);
  function automatic int g_of(input int s);
    case (s)
      0, 1, 2, 3: return s;
      4, 5, 6:    return 4;
      7, 8:       return 5;
      default:    return 6;
    endcase
  endfunction

  logic [9:0]  elig;
  logic [19:0] lvls;
  logic [1:0]  top_lvl;
  always_comb begin
    top_lvl = 2'd0;
    for (int s = 0; s < 10; s++) begin
      elig[s] = req_i[s] & en_i[7] & en_i[g_of(s)];
      lvls[2*s +: 2] = 2'(prio_lo_i[g_of(s)]) + (HAS_HI ? 2'(prio_hi_i[g_of(s)]) << 1 : 2'd0);
      if (elig[s] && lvls[2*s +: 2] > top_lvl) top_lvl = lvls[2*s +: 2];
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (!grant_valid_o && grant_idx_o == 4'd0 && grant_lvl_o == 2'd0));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(elig) == 10'd0) |-> (!grant_valid_o && grant_idx_o == 4'd0 && grant_lvl_o == 2'd0));

  assert_grant_eligible_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && grant_valid_o) |-> ((($past(elig) >> grant_idx_o) & 10'd1) == 10'd1));

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(en_i[7])) |-> !grant_valid_o);

  assert_level_match_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && grant_valid_o) |-> (grant_lvl_o == 2'(($past(lvls) >> (2 * grant_idx_o)) & 20'd3)));

  assert_level_max_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && grant_valid_o) |-> (grant_lvl_o == $past(top_lvl)));

  assert_found_any_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (grant_valid_o == ($past(elig) != 10'd0)));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.HAS_HI(HAS_HI)) u_chk (.*);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] req = '0;
  logic [7:0] en = '0;
  logic [6:0] lo = '0, hi = '0;
  logic       v_a, v_b;
  logic [3:0] i_a, i_b;
  logic [1:0] l_a, l_b;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_resolver #(.HAS_HI(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .prio_lo_i(lo), .prio_hi_i(hi),
    .grant_valid_o(v_a), .grant_idx_o(i_a), .grant_lvl_o(l_a));

  irq_prio_resolver #(.HAS_HI(1'b0)) u_dut_lo (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .prio_lo_i(lo), .prio_hi_i(hi),
    .grant_valid_o(v_b), .grant_idx_o(i_b), .grant_lvl_o(l_b));

  function automatic int grp(input int s);
    if (s <= 3) return s;
    if (s <= 6) return 4;
    if (s <= 8) return 5;
    return 6;
  endfunction

  function automatic logic [6:0] model(input logic [9:0] r, input logic [7:0] e,
                                       input logic [6:0] pl, input logic [6:0] ph, input bit usehi);
    int best_l = -1, best_i = 0;
    for (int s = 0; s < 10; s++) begin
      int g = grp(s);
      int l = pl[g] + (usehi ? 2 * ph[g] : 0);
      if (r[s] && e[7] && e[g] && l > best_l) begin
        best_l = l;
        best_i = s;
      end
    end
    if (best_l < 0) return 7'd0;
    return {1'b1, 4'(best_i), 2'(best_l)};
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v=%0b idx=%0d lvl=%0d, expected v=%0b idx=%0d lvl=%0d",
               tag, act[6], act[5:2], act[1:0], exp[6], exp[5:2], exp[1:0]);
    end
  endtask

  task automatic apply(input string tag, input logic [9:0] r, input logic [7:0] e,
                       input logic [6:0] pl, input logic [6:0] ph);
    req = r; en = e; lo = pl; hi = ph;
    @(posedge clk); #1;
    check({tag, " full"}, {v_a, i_a, l_a}, model(r, e, pl, ph, 1'b1));
    check({tag, " nohi R9"}, {v_b, i_b, l_b}, model(r, e, pl, ph, 1'b0));
  endtask

  initial begin
    logic [31:0] lf = 32'hACE1_2468;
    @(posedge clk); #1;
    req = 10'h3FF; en = 8'hFF; lo = 7'h7F; hi = 7'h7F;
    @(posedge clk); #1;
    check("R1 reset", {v_a, i_a, l_a}, 7'd0);
    rst = 1'b0;
    check("R1 first cycle after reset", {v_a, i_a, l_a}, 7'd0);
    @(posedge clk); #1;
    check("R8 first result", {v_a, i_a, l_a}, model(10'h3FF, 8'hFF, 7'h7F, 7'h7F, 1'b1));

    apply("R7 no requests", 10'h000, 8'hFF, 7'h55, 7'h2A);
    apply("R6 global enable off", 10'h3FF, 8'h7F, 7'h7F, 7'h7F);
    apply("R6 group enables off", 10'h3FF, 8'h80, 7'h00, 7'h00);
    apply("R3 level 3 beats index 0", 10'h201, 8'hFF, 7'h40, 7'h40);
    apply("R2 level 2 from high bit", 10'h008, 8'hFF, 7'h00, 7'h08);
    apply("R4 tie lowest index", 10'h00C, 8'hFF, 7'h00, 7'h00);
    apply("R5 serial trio", 10'h070, 8'hFF, 7'h10, 7'h10);
    apply("R5 serial pair", 10'h060, 8'hFF, 7'h10, 7'h00);
    apply("R5 timer2 pair", 10'h180, 8'hFF, 7'h20, 7'h20);
    apply("R6 serial group masked", 10'h071, 8'hEF, 7'h10, 7'h10);
    apply("R9 high bit only", 10'h201, 8'hFF, 7'h01, 7'h40);

    req = 10'h001; en = 8'hFF; lo = 7'h00; hi = 7'h00; #1;
    check("R8 output held before edge", {v_a, i_a, l_a}, model(10'h201, 8'hFF, 7'h01, 7'h40, 1'b1));
    @(posedge clk); #1;
    check("R8 output after edge", {v_a, i_a, l_a}, model(10'h001, 8'hFF, 7'h00, 7'h00, 1'b1));

    for (int r = 0; r < 1024; r++)
      apply("R4 request sweep", 10'(r), 8'hFF, 7'(r * 37), 7'(r * 91 + 5));

    for (int k = 0; k < 4000; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply("R3 mixed sweep", lf[9:0], lf[17:10] | 8'h80 & {8{lf[30]}}, lf[24:18], lf[31:25]);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule